// File: doc/BRIEF.md
# StreamID Span Pattern Filter

This block decides, for each of a set of event counters, whether an incoming transaction's StreamID passes that counter's filter. Each counter holds a filter pattern and a span flag. With the span flag clear, the StreamID must equal the pattern exactly. With it set, the pattern also carries its own don't-care width: the lowest zero bit of the pattern and every bit below it (a run of ones) are ignored, and only the bits above that zero are compared. A pattern of all ones with the span flag set therefore matches any StreamID. This is also the state after reset, so an unprogrammed counter counts everything.

A global mode makes counter 0's span flag and pattern govern every counter. The per-counter settings are kept and come back into use when the mode is cleared. Software programs the block through a small write port that selects a counter and one of three targets: the counter's type word (only the span bit is used), its pattern, or the shared mode flag. The result is a registered per-counter match vector. It comes with a valid flag one clock after each StreamID strobe and is meant to gate the increment of the event counters next to the block.

Top module: `sid_span_filter`

## Requirements
- R1: After reset every counter has span 1 and an all-ones pattern, global mode is off, and `match_vld` and `match` are 0.
- R2: `match_vld` and `match` are registered: a strobe on `sid_valid` in cycle t gives `match_vld`=1 and the result in cycle t+1. In a cycle after a cycle without a strobe, both outputs are 0.
- R3: With span 0, a counter matches only when every StreamID bit equals its pattern.
- R4: With span 1 and the lowest zero bit of the pattern at position k, StreamID bits k down to 0 are ignored and bits above k must equal the pattern. For example, pattern 0x42 matches 0x42 and 0x43 but not 0x41 or 0x44.
- R5: With span 1 and an all-ones pattern, a counter matches every StreamID.
- R6: A write with `wr_sel`=0 loads the selected counter's span flag from `wr_data` bit 29. The event identifier bits 15:0 and every other bit of that word have no effect on the filter.
- R7: A write with `wr_sel`=2 loads the global mode flag from `wr_data` bit 0. While the flag is 1, counter 0's span and pattern decide every counter's match. Clearing it restores each counter's own settings, which are left unchanged.
- R8: A write with `wr_sel`=1 loads the selected counter's pattern from `wr_data`. Any write affects strobes from the following cycle onward. A strobe in the same cycle as the write is filtered with the previous settings.
- R9: A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Settings write strobe |
| wr_sel | input | 2 | Write target: 0 type word, 1 pattern, 2 mode, 3 none |
| wr_ctr | input | CTR_IW | Counter addressed by a type word or pattern write |
| wr_data | input | DATA_W | Write data |
| sid_valid | input | 1 | StreamID strobe |
| sid | input | SID_W | Incoming StreamID |
| match_vld | output | 1 | Result valid, one cycle after the strobe |
| match | output | NUM_CTR | Per-counter pass flags |

## Verification
A wrong pattern, span flag or global flag inside the block shows at the ports on the first strobe after the corruption: one cycle later, the affected bit of `match` disagrees with the model. Because the strobes used in the bench sit near the programmed patterns, a one-bit error in the derived don't-care width changes the result for some StreamID within a few strobes. Errors in write timing or in the handling of the unused select code show on the strobe that directly follows the write.

// File: rtl/sid_filt_pkg.sv
package sid_filt_pkg;

    // write target codes on wr_sel
    typedef enum logic [1:0] {
        SEL_TYPE = 2'd0,
        SEL_PAT  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    // bit position of the span flag inside a counter type word
    localparam int SPAN_BIT = 29;
    // bit position of the global flag inside a mode word
    localparam int GLOB_BIT = 0;

endpackage

// File: rtl/sid_filt_cfg.sv
module sid_filt_cfg
    import sid_filt_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    parameter int DATA_W  = 32,
    parameter int CTR_IW  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [1:0]                      wr_sel,
    input  logic [CTR_IW-1:0]               wr_ctr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [NUM_CTR-1:0]              span_o,
    output logic [NUM_CTR-1:0][SID_W-1:0]   pat_o,
    output logic                            glob_o
);

    typedef struct packed {
        logic [NUM_CTR-1:0]            span;
        logic [NUM_CTR-1:0][SID_W-1:0] pat;
        logic                          glob;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic ctr_ok;
    logic unused_bits;

    assign ctr_ok      = (32'(wr_ctr) < NUM_CTR);
    assign unused_bits = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_sel_e'(wr_sel))
                SEL_TYPE: if (ctr_ok) cfg_d.span[wr_ctr] = wr_data[SPAN_BIT];
                SEL_PAT:  if (ctr_ok) cfg_d.pat[wr_ctr]  = wr_data[SID_W-1:0];
                SEL_MODE: cfg_d.glob = wr_data[GLOB_BIT];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.span <= '1;
            cfg_q.pat  <= '1;
            cfg_q.glob <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign span_o = cfg_q.span;
    assign pat_o  = cfg_q.pat;
    assign glob_o = cfg_q.glob;

endmodule

// File: rtl/sid_span_mask.sv
module sid_span_mask #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] pat,
    input  logic             span,
    output logic [SID_W-1:0] care
);

    logic [SID_W-1:0] pat_inc;
    logic [SID_W-1:0] dont_care;
    logic             all_ones;

    // pattern XOR (pattern+1) sets bits 0..k where k is the lowest zero
    assign pat_inc   = pat + SID_W'(1);
    assign dont_care = pat ^ pat_inc;
    assign all_ones  = &pat;

    always_comb begin
        if (!span) begin
            care = '1;
        end else if (all_ones) begin
            care = '0;
        end else begin
            care = ~dont_care;
        end
    end

endmodule

// File: rtl/sid_match_lane.sv
module sid_match_lane #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] pat,
    input  logic             span,
    input  logic [SID_W-1:0] sid,
    output logic             hit
);

    logic [SID_W-1:0] care;

    sid_span_mask #(.SID_W(SID_W)) u_mask (
        .pat  (pat),
        .span (span),
        .care (care)
    );

    assign hit = ((sid ^ pat) & care) == '0;

endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
    import sid_filt_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    parameter int DATA_W  = 32,
    parameter int CTR_IW  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CTR_IW-1:0]  wr_ctr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               sid_valid,
    input  logic [SID_W-1:0]   sid,
    output logic               match_vld,
    output logic [NUM_CTR-1:0] match
);

    typedef struct packed {
        logic               vld;
        logic [NUM_CTR-1:0] hit;
    } res_t;

    logic [NUM_CTR-1:0]            span_q;
    logic [NUM_CTR-1:0][SID_W-1:0] pat_q;
    logic                          glob_q;
    logic [NUM_CTR-1:0]            lane_hit;
    res_t                          res_d, res_q;

    sid_filt_cfg #(
        .NUM_CTR (NUM_CTR),
        .SID_W   (SID_W),
        .DATA_W  (DATA_W),
        .CTR_IW  (CTR_IW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_ctr  (wr_ctr),
        .wr_data (wr_data),
        .span_o  (span_q),
        .pat_o   (pat_q),
        .glob_o  (glob_q)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
        logic [SID_W-1:0] lane_pat;
        logic             lane_span;
        if (i == 0) begin : g_root
            assign lane_pat  = pat_q[0];
            assign lane_span = span_q[0];
        end else begin : g_dep
            assign lane_pat  = glob_q ? pat_q[0]  : pat_q[i];
            assign lane_span = glob_q ? span_q[0] : span_q[i];
        end
        sid_match_lane #(.SID_W(SID_W)) u_lane (
            .pat  (lane_pat),
            .span (lane_span),
            .sid  (sid),
            .hit  (lane_hit[i])
        );
    end

    always_comb begin
        res_d.vld = sid_valid;
        res_d.hit = sid_valid ? lane_hit : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign match_vld = res_q.vld;
    assign match     = res_q.hit;

endmodule

// File: rtl/sid_span_filter_chk.sv
module sid_span_filter_chk #(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [1:0]                    wr_sel,
    input logic                          sid_valid,
    input logic [SID_W-1:0]              sid,
    input logic [NUM_CTR-1:0]            span_q,
    input logic [NUM_CTR-1:0][SID_W-1:0] pat_q,
    input logic                          glob_q,
    input logic                          match_vld,
    input logic [NUM_CTR-1:0]            match
);

    logic touched_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) touched_q <= 1'b0;
        else if (wr_en && wr_sel != 2'd3) touched_q <= 1'b1;
    end

    // R2: a strobe is answered on the next cycle
    p_vld_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sid_valid |=> match_vld);

    // R2: no result flags without a valid result
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !match_vld |-> (match == '0));

    // R5: untouched defaults pass every StreamID
    p_default_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && !touched_q) |-> (&match));

    // R3: exact mode on counter 0
    p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && !$past(span_q[0])) |-> (match[0] == ($past(sid) == $past(pat_q[0]))));

    // R4: a StreamID equal to the pattern always passes
    p_self_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && ($past(sid) == $past(pat_q[0]))) |-> match[0]);

    // R7: global mode makes all counters agree
    p_global_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && $past(glob_q)) |-> (match == {NUM_CTR{match[0]}}));

endmodule

bind sid_span_filter sid_span_filter_chk #(
    .NUM_CTR (NUM_CTR),
    .SID_W   (SID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .sid_valid (sid_valid),
    .sid       (sid),
    .span_q    (span_q),
    .pat_q     (pat_q),
    .glob_q    (glob_q),
    .match_vld (match_vld),
    .match     (match)
);

// File: tb/sid_span_filter_test.sv
module sid_span_filter_test;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [1:0]  wr_ctr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        sid_valid = 1'b0;
    logic [31:0] sid = 32'd0;
    logic        match_vld;
    logic [3:0]  match;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    // behavioural model state
    bit          m_span [NC];
    logic [31:0] m_pat  [NC];
    bit          m_glob;
    bit          e_vld;
    logic [3:0]  e_match;

    sid_span_filter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_ctr    (wr_ctr),
        .wr_data   (wr_data),
        .sid_valid (sid_valid),
        .sid       (sid),
        .match_vld (match_vld),
        .match     (match)
    );

    always #5 clk = ~clk;

    function automatic bit ref_hit(logic [31:0] p, bit sp, logic [31:0] s);
        if (!sp) return p == s;
        for (int y = 0; y < 32; y++) begin
            if (!p[y]) return (p >> (y + 1)) == (s >> (y + 1));
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin
                m_span[i] = 1'b1;
                m_pat[i]  = 32'hFFFF_FFFF;
            end
            m_glob  = 1'b0;
            e_vld   = 1'b0;
            e_match = 4'd0;
        end else begin
            e_vld = sid_valid;
            for (int i = 0; i < NC; i++) begin
                e_match[i] = sid_valid &&
                    ref_hit(m_glob ? m_pat[0] : m_pat[i], m_glob ? m_span[0] : m_span[i], sid);
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_span[wr_ctr] = wr_data[29];
                    2'd1: m_pat[wr_ctr]  = wr_data;
                    2'd2: m_glob         = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2 cycle vld", {31'd0, match_vld}, {31'd0, e_vld});
            chk("R2 cycle match", {28'd0, match}, {28'd0, e_match});
        end
    end

    task automatic wr(logic [1:0] s, logic [1:0] c, logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_ctr = c; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic probe(string tag, logic [31:0] s, logic [3:0] exp);
        @(negedge clk); #1;
        sid_valid = 1'b1; sid = s;
        @(negedge clk);
        chk({tag, " vld"}, {31'd0, match_vld}, 32'd1);
        chk(tag, {28'd0, match}, {28'd0, exp});
        #1 sid_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset vld", {31'd0, match_vld}, 32'd0);
        chk("R1 reset match", {28'd0, match}, 32'd0);
        rst_n = 1'b1;
        started = 1'b1;

        probe("R1 R5 default", 32'hDEAD_BEEF, 4'b1111);

        // counter 1: exact match
        wr(2'd0, 2'd1, 32'h0000_ABCD);
        wr(2'd1, 2'd1, 32'h0000_1234);
        probe("R3 exact hit", 32'h0000_1234, 4'b1111);
        probe("R3 exact miss", 32'h0000_1235, 4'b1101);
        // R6: only bit 29 of the type word matters
        wr(2'd0, 2'd1, 32'h2000_FFFF);
        probe("R6 span bit set", 32'h0000_1235, 4'b1111);
        wr(2'd0, 2'd1, 32'hDFFF_FFFF);
        probe("R6 span bit clear", 32'h0000_1235, 4'b1101);

        // counter 2: 0x42 prefix
        wr(2'd1, 2'd2, 32'h0000_0042);
        probe("R4 0x42", 32'h0000_0042, 4'b1101);
        probe("R4 0x43", 32'h0000_0043, 4'b1101);
        probe("R4 0x41", 32'h0000_0041, 4'b1001);
        probe("R4 0x44", 32'h0000_0044, 4'b1001);
        // counter 3: five low bits ignored
        wr(2'd1, 2'd3, 32'hFFFF_FF0F);
        probe("R4 wide span hit", 32'hFFFF_FF00, 4'b1001);
        probe("R4 wide span miss", 32'hFFFF_FF20, 4'b0001);

        wr(2'd1, 2'd3, 32'hFFFF_FFFF);
        probe("R5 all ones", 32'h0000_0000, 4'b1001);

        // R9: unused select
        wr(2'd3, 2'd0, 32'h0000_0000);
        probe("R9 no effect", 32'h0000_0000, 4'b1001);

        // R8: write and strobe together
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = 2'd1; wr_ctr = 2'd0; wr_data = 32'h0000_0005;
        sid_valid = 1'b1; sid = 32'h0000_0000;
        @(negedge clk);
        chk("R8 old settings", {28'd0, match}, 32'h9);
        #1 wr_en = 1'b0; sid_valid = 1'b0;
        probe("R8 new settings", 32'h0000_0000, 4'b1000);
        probe("R8 new settings hit", 32'h0000_0006, 4'b1001);

        // R7: global mode
        wr(2'd0, 2'd0, 32'h0000_0000);
        wr(2'd1, 2'd0, 32'h0000_0077);
        wr(2'd2, 2'd0, 32'h0000_0001);
        probe("R7 global hit", 32'h0000_0077, 4'b1111);
        probe("R7 global miss", 32'h0000_1234, 4'b0000);
        wr(2'd2, 2'd0, 32'h0000_0000);
        probe("R7 restored", 32'h0000_1234, 4'b1010);

        @(negedge clk);
        chk("R2 idle vld", {31'd0, match_vld}, 32'd0);
        chk("R2 idle match", {28'd0, match}, 32'd0);

        // random traffic near the patterns
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            wr_en = ($urandom_range(3) == 0);
            wr_sel = 2'($urandom_range(3));
            wr_ctr = 2'($urandom_range(3));
            if ($urandom_range(7) == 0) wr_data = 32'hFFFF_FFFF;
            else wr_data = {($urandom_range(1) == 1) ? 4'h2 : 4'h0, 24'h000_00A, 4'($urandom)};
            sid_valid = ($urandom_range(1) == 1);
            sid = {4'h0, 24'h000_00A, 4'($urandom)};
        end
        @(negedge clk); #1;
        wr_en = 1'b0; sid_valid = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule